// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block collects event notifications into an 8-bit pending register, gates them with an 8-bit enable mask, and drives one active-low interrupt line. The pending register is fed by generic event strobes, by an internal periodic tick, and by a peripheral reply buffer. When the reply is committed, the reply bit is set, and also the auto-poll bit if a poll produced the reply. An auto-poll timer asks an external device for data at a fixed cadence while an auto-poll mask is active. It holds off while a peripheral reply is still unread.

Software talks to the block through a small request port. A request has a kind, an argument count and up to 16 argument bits. It can write the interrupt mask, set the auto-poll mask, or acknowledge pending events. The acknowledge is selective. If a peripheral reply is waiting, the block returns only the reply and auto-poll bits, followed by the buffered reply bytes, and clears only those. Otherwise it returns every pending bit in one byte and clears them all.

The answer leaves as a byte stream, one byte per cycle, and carries its total length. The stream is run by a state machine with three states:
- S_IDLE: waiting.
- S_HEAD: presenting the status byte.
- S_BODY: presenting reply bytes.

The transitions are:
- idle-to-head, on an accepted acknowledge.
- head-to-idle, when no reply bytes follow.
- head-to-body, when reply bytes follow.
- body-to-body, while bytes remain.
- body-to-idle, after the last byte.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset all pending bits are zero, and the mask enables only bit 0 (peripheral reply) and bit 2 (tick). The interrupt is therefore high, no stream is active, no poll is requested and the auto-poll mask is zero. Bit 1 is the auto-poll bit.
- R2: `irq_n` is low exactly when (pending AND mask) is nonzero. It changes right after the clock edge that changes the pending bits or the mask.
- R3: The tick sets pending bit 2 at clock edge TICK_CYCLES after reset release, and then at every further multiple of TICK_CYCLES, with no drift from acknowledges.
- R4: Acknowledging while bit 0 is pending does the following:
  - The stream is a status byte equal to pending AND 0x03, followed by the buffered reply bytes in load order.
  - `out_len` is the byte count plus one, and `out_last` marks the final byte.
  - Bits 0 and 1 and the buffer are cleared; all other pending bits are kept.
- R5: Acknowledging while bit 0 is clear returns one byte equal to all pending bits, with `out_len` 1, and clears all of them.
- R6: Request kinds are encoded as 0 acknowledge, 1 mask write and 2 auto-poll write; kind 3 does nothing. A request is ignored unless its argument count is exactly 0, 1 or 2 for kinds 0, 1 or 2 respectively.
- R7: An accepted mask write loads `req_arg[7:0]` into the mask.
- R8: An accepted nonzero auto-poll write (`req_arg[15:0]`) restarts the poll timer. `poll_req` then pulses for one cycle POLL_CYCLES edges after the accepting edge, and every POLL_CYCLES edges after that.
- R9: A poll pulse that falls while bit 0 is pending, or while a stream is active, is suppressed. The cadence continues unchanged.
- R10: Reply bytes are loaded in order, up to DEPTH of them. A commit sets bit 0, and also bit 1 when `ld_auto` is high. Loads and commits are ignored while bit 0 is pending or a stream is active.
- R11: An auto-poll write equal to the current auto-poll mask has no effect on the cadence. A zero auto-poll mask stops all poll pulses.
- R12: An event set in the same cycle as an acknowledge clear wins. That bit stays pending and is absent from that acknowledge's status byte.
- R13: Requests that arrive while a stream is active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 8 | Per-bit event set strobes |
| ld_valid | input | 1 | Append `ld_data` to the reply buffer |
| ld_data | input | 8 | Reply byte |
| ld_commit | input | 1 | Mark the buffered reply ready |
| ld_auto | input | 1 | The committed reply came from a poll |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 acknowledge, 1 mask write, 2 auto-poll write |
| req_argc | input | 3 | Argument count of the request |
| req_arg | input | 16 | Argument bits |
| irq_n | output | 1 | Active-low interrupt |
| poll_req | output | 1 | One-cycle poll request to the device side |
| poll_mask | output | 16 | Current auto-poll mask |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the stream |
| out_len | output | LENW | Total stream length |

## Verification
A corrupted pending bit or mask shows on `irq_n` in the cycle after the faulty edge. It also appears in the status byte of the next acknowledge, so each event path is followed by an acknowledge whose header is checked exactly. A wrong reply count or read index shows in the `out_len`, `out_last` and body bytes of that same stream. A poll or tick counter that is off by one edge moves a pulse, so those pulses are sampled at exact edge counts on both sides of the expected instant.

// File: rtl/evtagg_pkg.sv
package evtagg_pkg;
    localparam int unsigned EVW       = 8;
    localparam int unsigned BIT_REPLY = 0;
    localparam int unsigned BIT_AUTO  = 1;
    localparam int unsigned BIT_TICK  = 2;

    localparam logic [EVW-1:0] REPLY_MSK  = EVW'(1) << BIT_REPLY;
    localparam logic [EVW-1:0] AUTO_MSK   = EVW'(1) << BIT_AUTO;
    localparam logic [EVW-1:0] TICK_MSK   = EVW'(1) << BIT_TICK;
    localparam logic [EVW-1:0] PERIPH_MSK = REPLY_MSK | AUTO_MSK;
    localparam logic [EVW-1:0] RESET_MASK = REPLY_MSK | TICK_MSK;

    typedef enum logic [1:0] {
        REQ_ACK  = 2'd0,
        REQ_MASK = 2'd1,
        REQ_POLL = 2'd2,
        REQ_NOP  = 2'd3
    } req_kind_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HEAD = 2'd1,
        S_BODY = 2'd2
    } ack_state_t;
endpackage

// File: rtl/evtagg_period_timer.sv
module evtagg_period_timer #(
    parameter int unsigned PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic fire
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    assign fire = en && (cnt_q == LAST);

    // R3: the counter never runs past its last phase
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    if (PERIOD > 1) begin : g_gap
        // R3: pulses are single cycles, never back to back
        p_fire_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (fire && !restart) |=> !fire);
    end
endmodule

// File: rtl/evtagg_reply_buf.sv
module evtagg_reply_buf #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LENW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    input  logic            clr,
    input  logic [LENW-1:0] rd_idx,
    output logic [LENW-1:0] count,
    output logic [7:0]      rd_data
);
    localparam int unsigned IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]      mem_q [DEPTH];
    logic [LENW-1:0] cnt_q;
    logic            room;

    assign room = (cnt_q < LENW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (wr_en && room) begin
            cnt_q <= cnt_q + LENW'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else if (wr_en && room && !clr && (cnt_q == LENW'(i))) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    assign count   = cnt_q;
    assign rd_data = mem_q[rd_idx[IDXW-1:0]];

    // R10: the buffer never holds more than DEPTH bytes
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LENW'(DEPTH));

    // R4: a clear empties the buffer on the next edge
    p_clr_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/evtagg_ack_fsm.sv
module evtagg_ack_fsm
    import evtagg_pkg::*;
#(
    parameter int unsigned LENW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [EVW-1:0]  hdr_in,
    input  logic [LENW-1:0] body_len_in,
    input  logic [7:0]      rd_data,
    output logic [LENW-1:0] rd_idx,
    output logic            busy,
    output logic            out_valid,
    output logic [7:0]      out_data,
    output logic            out_last,
    output logic [LENW-1:0] out_len
);
    ack_state_t      state_q, state_d;
    logic [EVW-1:0]  hdr_q;
    logic [LENW-1:0] len_q;
    logic [LENW-1:0] idx_q;
    logic            body_end;

    assign body_end = (idx_q == len_q - LENW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_HEAD;
            S_HEAD: state_d = (len_q == '0) ? S_IDLE : S_BODY;
            S_BODY: if (body_end) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hdr_q   <= '0;
            len_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                hdr_q <= hdr_in;
                len_q <= body_len_in;
                idx_q <= '0;
            end else if (state_q == S_BODY && !body_end) begin
                idx_q <= idx_q + LENW'(1);
            end
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_HEAD: begin
                out_valid = 1'b1;
                out_data  = hdr_q;
                out_last  = (len_q == '0);
            end
            S_BODY: begin
                out_valid = 1'b1;
                out_data  = rd_data;
                out_last  = body_end;
            end
            default: ;
        endcase
    end

    assign out_len = len_q + LENW'(1);
    assign rd_idx  = idx_q;
    assign busy    = (state_q != S_IDLE);

    // R4: the body index stays inside the captured reply length
    p_body_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BODY) |-> (idx_q < len_q));

    // R4: the status byte is shown for exactly one cycle
    p_head_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HEAD) |=> (state_q != S_HEAD));
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
    import evtagg_pkg::*;
#(
    parameter int unsigned TICK_CYCLES = 50_000_000,
    parameter int unsigned POLL_CYCLES = 1_500_000,
    parameter int unsigned DEPTH       = 8,
    localparam int unsigned LENW       = $clog2(DEPTH + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      evt_set,
    input  logic            ld_valid,
    input  logic [7:0]      ld_data,
    input  logic            ld_commit,
    input  logic            ld_auto,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic [2:0]      req_argc,
    input  logic [15:0]     req_arg,
    output logic            irq_n,
    output logic            poll_req,
    output logic [15:0]     poll_mask,
    output logic            out_valid,
    output logic [7:0]      out_data,
    output logic            out_last,
    output logic [LENW-1:0] out_len
);
    logic [EVW-1:0]  pend_q, mask_q;
    logic [15:0]     pmask_q;
    logic            busy, idle;
    logic            ack_ok, mask_ok, poll_ok;
    logic            load_open, wr_en, commit_ok;
    logic            reply_pending;
    logic [EVW-1:0]  set_vec, clr_vec, hdr;
    logic [LENW-1:0] buf_count, rd_idx, body_len;
    logic [7:0]      rd_data;
    logic            tick_fire, poll_fire;
    req_kind_t       kind;

    assign kind          = req_kind_t'(req_kind);
    assign idle          = !busy;
    assign reply_pending = pend_q[BIT_REPLY];

    // request decode: only taken while no stream is running
    assign ack_ok  = req_valid && idle && (kind == REQ_ACK)  && (req_argc == 3'd0);
    assign mask_ok = req_valid && idle && (kind == REQ_MASK) && (req_argc == 3'd1);
    assign poll_ok = req_valid && idle && (kind == REQ_POLL) && (req_argc == 3'd2)
                     && (req_arg != pmask_q);

    // reply loading is closed while an unread reply or a stream exists
    assign load_open = idle && !reply_pending;
    assign wr_en     = ld_valid && load_open;
    assign commit_ok = ld_commit && load_open;

    assign hdr      = reply_pending ? (pend_q & PERIPH_MSK) : pend_q;
    assign body_len = reply_pending ? buf_count : '0;
    assign clr_vec  = ack_ok ? (reply_pending ? PERIPH_MSK : {EVW{1'b1}}) : '0;
    assign set_vec  = evt_set
                    | (tick_fire ? TICK_MSK : '0)
                    | (commit_ok ? (REPLY_MSK | (ld_auto ? AUTO_MSK : '0)) : '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= RESET_MASK;
            pmask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | set_vec;
            if (mask_ok) mask_q  <= req_arg[EVW-1:0];
            if (poll_ok) pmask_q <= req_arg;
        end
    end

    evtagg_period_timer #(.PERIOD(TICK_CYCLES)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (1'b1),
        .restart (1'b0),
        .fire    (tick_fire)
    );

    evtagg_period_timer #(.PERIOD(POLL_CYCLES)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pmask_q != '0),
        .restart (poll_ok && (req_arg != '0)),
        .fire    (poll_fire)
    );

    evtagg_reply_buf #(.DEPTH(DEPTH), .LENW(LENW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (ld_data),
        .clr     (ack_ok && reply_pending),
        .rd_idx  (rd_idx),
        .count   (buf_count),
        .rd_data (rd_data)
    );

    evtagg_ack_fsm #(.LENW(LENW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (ack_ok),
        .hdr_in      (hdr),
        .body_len_in (body_len),
        .rd_data     (rd_data),
        .rd_idx      (rd_idx),
        .busy        (busy),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_last    (out_last),
        .out_len     (out_len)
    );

    assign irq_n     = ~|(pend_q & mask_q);
    assign poll_req  = poll_fire && idle && !reply_pending;
    assign poll_mask = pmask_q;

    // R5: a full acknowledge leaves only same-cycle sets pending
    p_ack_all_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && !reply_pending) |=> ((pend_q & ~$past(set_vec)) == '0));

    // R4: a reply acknowledge drops the peripheral bits and the buffer
    p_ack_reply_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && reply_pending) |=>
            (((pend_q & PERIPH_MSK & ~$past(set_vec)) == '0) && (buf_count == '0)));

    // R12: every set strobe is visible as pending on the next edge
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    // R13: requests during a stream leave both masks untouched
    p_busy_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ((mask_q == $past(mask_q)) && (pmask_q == $past(pmask_q))));

    // R8: polls are only requested while auto-polling is on
    p_poll_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> (pmask_q != '0));
endmodule

// File: tb/sim_evt_irq_agg.sv
module sim_evt_irq_agg;
    localparam int CLK_PERIOD = 10;
    localparam int TICK  = 5000;
    localparam int POLL  = 20;
    localparam int DEPTH = 8;
    localparam int LENW  = $clog2(DEPTH + 2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      evt_set = '0;
    logic            ld_valid = 1'b0;
    logic [7:0]      ld_data = '0;
    logic            ld_commit = 1'b0;
    logic            ld_auto = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_kind = '0;
    logic [2:0]      req_argc = '0;
    logic [15:0]     req_arg = '0;
    logic            irq_n, poll_req, out_valid, out_last;
    logic [15:0]     poll_mask;
    logic [7:0]      out_data;
    logic [LENW-1:0] out_len;

    int total = 0;
    int bad = 0;
    int ecount = 0;
    bit finished = 0;
    logic [7:0] got [16];
    logic [7:0] exp_body [16];
    int got_n, got_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    evt_irq_agg #(.TICK_CYCLES(TICK), .POLL_CYCLES(POLL), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set),
        .ld_valid(ld_valid), .ld_data(ld_data), .ld_commit(ld_commit), .ld_auto(ld_auto),
        .req_valid(req_valid), .req_kind(req_kind), .req_argc(req_argc), .req_arg(req_arg),
        .irq_n(irq_n), .poll_req(poll_req), .poll_mask(poll_mask),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_len(out_len)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_until(input int n);
        while (ecount < n) @(negedge clk);
    endtask

    task automatic send_req(input logic [1:0] k, input logic [2:0] c, input logic [15:0] a);
        req_valid = 1'b1; req_kind = k; req_argc = c; req_arg = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_evt(input logic [7:0] v);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic load_reply(input int n, input logic [7:0] base, input bit autob);
        for (int i = 0; i < n; i++) begin
            ld_valid = 1'b1; ld_data = base + 8'(i);
            @(negedge clk);
        end
        ld_valid = 1'b0;
        ld_commit = 1'b1; ld_auto = autob;
        @(negedge clk);
        ld_commit = 1'b0; ld_auto = 1'b0;
    endtask

    task automatic collect();
        got_n = 0;
        got_len = 0;
        if (out_valid) got_len = int'(out_len);
        for (int i = 0; i < 16; i++) begin
            if (!out_valid) break;
            got[got_n] = out_data;
            got_n++;
            @(negedge clk);
            if (got[got_n-1] === got[got_n-1] && !out_valid) break;
        end
    endtask

    task automatic ack_check(input logic [7:0] hdr, input int n, input string tag);
        send_req(2'd0, 3'd0, 16'h0);
        collect();
        chk(got_n == n + 1, {tag, " stream bytes"}, got_n, n + 1);
        chk(got_len == n + 1, {tag, " out_len"}, got_len, n + 1);
        chk(got[0] == hdr, {tag, " status byte"}, got[0], hdr);
        for (int i = 0; i < n; i++)
            chk(got[i+1] == exp_body[i], {tag, " reply byte"}, got[i+1], exp_body[i]);
    endtask

    // R1 R2 R5: reset values and default mask
    task automatic t_reset();
        chk(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);
        chk(out_valid == 1'b0, "R1 no stream after reset", out_valid, 0);
        chk(poll_req == 1'b0 && poll_mask == 16'h0, "R1 poll idle after reset", poll_mask, 0);
        pulse_evt(8'h02);
        chk(irq_n == 1'b1, "R1 bit1 masked at reset", irq_n, 1);
        ack_check(8'h02, 0, "R5 ack bit1");
        pulse_evt(8'h04);
        chk(irq_n == 1'b0, "R2 tick bit enabled", irq_n, 0);
        ack_check(8'h04, 0, "R5 ack bit2");
        chk(irq_n == 1'b1, "R2 irq released after ack", irq_n, 1);
    endtask

    // R7 R2: mask writes
    task automatic t_mask();
        pulse_evt(8'h80);
        chk(irq_n == 1'b1, "R2 bit7 masked", irq_n, 1);
        send_req(2'd1, 3'd1, 16'h0080);
        chk(irq_n == 1'b0, "R7 mask write enables bit7", irq_n, 0);
        send_req(2'd1, 3'd1, 16'h0000);
        chk(irq_n == 1'b1, "R7 mask write zero", irq_n, 1);
        ack_check(8'h80, 0, "R5 ack bit7");
        send_req(2'd1, 3'd1, 16'h0005);
    endtask

    // R6: argument count and kind checks
    task automatic t_argc();
        pulse_evt(8'h80);
        send_req(2'd1, 3'd0, 16'h0080);
        chk(irq_n == 1'b1, "R6 mask write argc0 ignored", irq_n, 1);
        send_req(2'd1, 3'd2, 16'h0080);
        chk(irq_n == 1'b1, "R6 mask write argc2 ignored", irq_n, 1);
        send_req(2'd0, 3'd1, 16'h0);
        chk(out_valid == 1'b0, "R6 ack argc1 ignored", out_valid, 0);
        send_req(2'd3, 3'd0, 16'h0);
        chk(out_valid == 1'b0, "R6 kind3 ignored", out_valid, 0);
        send_req(2'd2, 3'd1, 16'h0005);
        chk(poll_mask == 16'h0, "R6 poll write argc1 ignored", poll_mask, 0);
        ack_check(8'h80, 0, "R6 bit7 still pending");
    endtask

    // R4 R10 R5: reply acknowledge path
    task automatic t_reply();
        pulse_evt(8'h40);
        load_reply(3, 8'hA1, 1'b0);
        chk(irq_n == 1'b0, "R10 commit raises irq", irq_n, 0);
        exp_body[0] = 8'hA1; exp_body[1] = 8'hA2; exp_body[2] = 8'hA3;
        ack_check(8'h01, 3, "R4 reply ack");
        chk(irq_n == 1'b1, "R4 reply bits cleared", irq_n, 1);
        ack_check(8'h40, 0, "R4 other bits kept");
    endtask

    // R10 R4: load gating, auto flag, empty reply
    task automatic t_gate();
        load_reply(1, 8'h5A, 1'b1);
        load_reply(1, 8'h77, 1'b0);
        exp_body[0] = 8'h5A;
        ack_check(8'h03, 1, "R10 second load ignored");
        ack_check(8'h00, 0, "R4 auto bit cleared");
        load_reply(0, 8'h00, 1'b0);
        ack_check(8'h01, 0, "R4 empty reply");
    endtask

    // R12: set wins over same-cycle clear
    task automatic t_priority();
        evt_set = 8'h20;
        send_req(2'd0, 3'd0, 16'h0);
        evt_set = '0;
        collect();
        chk(got_n == 1 && got[0] == 8'h00, "R12 set absent from header", got[0], 0);
        ack_check(8'h20, 0, "R12 set survived clear");
        load_reply(2, 8'h10, 1'b0);
        evt_set = 8'h01;
        send_req(2'd0, 3'd0, 16'h0);
        evt_set = '0;
        collect();
        chk(got_n == 3 && got[0] == 8'h01, "R12 reply header", got_n, 3);
        ack_check(8'h01, 0, "R12 reply bit re-set");
    endtask

    // R13: requests during a stream are dropped
    task automatic t_busy();
        pulse_evt(8'h80);
        load_reply(3, 8'hC0, 1'b0);
        send_req(2'd0, 3'd0, 16'h0);
        chk(out_valid == 1'b1 && out_data == 8'h01, "R13 stream started", out_data, 1);
        send_req(2'd1, 3'd1, 16'h0080);
        send_req(2'd2, 3'd2, 16'h1234);
        for (int i = 0; i < 8; i++) if (out_valid) @(negedge clk);
        chk(irq_n == 1'b1, "R13 mask write during stream ignored", irq_n, 1);
        chk(poll_mask == 16'h0, "R13 poll write during stream ignored", poll_mask, 0);
        ack_check(8'h80, 0, "R13 cleanup");
    endtask

    // R8 R9 R11: auto-poll cadence
    task automatic t_poll();
        int k, k2;
        bit seen;
        k = ecount;
        send_req(2'd2, 3'd2, 16'h00F0);
        chk(poll_mask == 16'h00F0, "R8 poll mask loaded", poll_mask, 16'h00F0);
        wait_until(k + POLL - 1);
        chk(poll_req == 1'b0, "R8 no early poll", poll_req, 0);
        wait_until(k + POLL);
        chk(poll_req == 1'b1, "R8 first poll", poll_req, 1);
        wait_until(k + POLL + 1);
        chk(poll_req == 1'b0, "R8 poll is one cycle", poll_req, 0);
        wait_until(k + POLL + 5);
        send_req(2'd2, 3'd2, 16'h00F0);
        wait_until(k + 2*POLL - 1);
        chk(poll_req == 1'b0, "R11 same mask no restart early", poll_req, 0);
        wait_until(k + 2*POLL);
        chk(poll_req == 1'b1, "R11 same mask keeps cadence", poll_req, 1);
        @(negedge clk);
        load_reply(1, 8'hEE, 1'b1);
        wait_until(k + 3*POLL);
        chk(poll_req == 1'b0, "R9 poll held while reply pending", poll_req, 0);
        @(negedge clk);
        exp_body[0] = 8'hEE;
        ack_check(8'h03, 1, "R9 polled reply");
        wait_until(k + 4*POLL);
        chk(poll_req == 1'b1, "R9 cadence kept", poll_req, 1);
        @(negedge clk);
        send_req(2'd2, 3'd2, 16'h0000);
        seen = 0;
        for (int i = 0; i < 3*POLL; i++) begin
            if (poll_req) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R11 zero mask stops polling", seen, 0);
        k2 = ecount;
        send_req(2'd2, 3'd2, 16'h0003);
        wait_until(k2 + POLL);
        chk(poll_req == 1'b1, "R8 restart after zero", poll_req, 1);
        @(negedge clk);
        send_req(2'd2, 3'd2, 16'h0000);
    endtask

    // R3: tick cadence from reset, no drift
    task automatic t_tick();
        do_reset();
        wait_until(TICK - 1);
        chk(irq_n == 1'b1, "R3 no early tick", irq_n, 1);
        wait_until(TICK);
        chk(irq_n == 1'b0, "R3 first tick", irq_n, 0);
        ack_check(8'h04, 0, "R3 tick header");
        wait_until(2*TICK - 1);
        chk(irq_n == 1'b1, "R3 no early second tick", irq_n, 1);
        wait_until(2*TICK);
        chk(irq_n == 1'b0, "R3 second tick on schedule", irq_n, 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_mask();
        t_argc();
        t_reply();
        t_gate();
        t_priority();
        t_busy();
        t_poll();
        t_tick();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule